// File: doc/BRIEF.md
# Quad Recirculating Serial Shift Register

The block contains four separate serial shift registers, lanes A, B, C and D. Each lane is `STAGES` flip-flops long, with 64 as the default. Each lane has its own clock, its own serial input and its own serial output. The output is the last stage. On a rising edge of a lane's clock, every bit moves one stage toward the output. The first stage then takes a new bit from one of two sources. In source state `SRC_EXT`, the new bit comes from the lane's serial input. In source state `SRC_LOOP`, the lane's own output is fed back, so the stored pattern circulates and any bit can be picked off when it passes the output.

Two loop controls choose the source state. `loop_ab` serves lanes A and B, and `loop_cd` serves lanes C and D. The source state has no memory of its own. It is decided again at every shift edge from the loop control's level at that edge. A high level moves it to `SRC_LOOP` and a low level moves it to `SRC_EXT`. There is no reset, so the contents at power-up are undefined until a lane has been filled.

An output can drive another lane's input directly. Cascading lanes this way gives longer delay lines.

Top module: `quad_recirc_shreg`

## Requirements
- R1: A bit loaded through a lane's serial input appears on that lane's output after exactly `STAGES` rising edges of that lane's clock (64 by default). It does not appear after any fewer edges.
- R2: A lane shifts only on a rising edge of its own clock. Edges on the other three clocks leave its output and its contents unchanged.
- R3: `loop_ab` selects the source for lanes A and B only. `loop_cd` selects the source for lanes C and D only.
- R4: When the lane's loop control is high (1) at a shift edge, the lane's output before the edge enters the first stage, and the serial input has no effect.
- R5: When the lane's loop control is low (0) at a shift edge, the serial input enters the first stage.
- R6: While the loop control stays high, a lane's output sequence repeats with a period of exactly `STAGES` edges.
- R7: An output fed straight into another lane's input, with both lanes clocked together, makes a delay line that is twice `STAGES` long.
- R8: The loop control is sampled at the same edge that performs the shift, with no added latency. A change applied before one edge governs that edge only.
- R9: Changing a shared loop control while a lane's clock is idle does not change that lane's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Shift clock, lane A |
| clk_b | input | 1 | Shift clock, lane B |
| clk_c | input | 1 | Shift clock, lane C |
| clk_d | input | 1 | Shift clock, lane D |
| sin_a | input | 1 | Serial input, lane A |
| sin_b | input | 1 | Serial input, lane B |
| sin_c | input | 1 | Serial input, lane C |
| sin_d | input | 1 | Serial input, lane D |
| loop_ab | input | 1 | Loop control for lanes A and B (1 = circulate) |
| loop_cd | input | 1 | Loop control for lanes C and D (1 = circulate) |
| sout_a | output | 1 | Last stage, lane A |
| sout_b | output | 1 | Last stage, lane B |
| sout_c | output | 1 | Last stage, lane C |
| sout_d | output | 1 | Last stage, lane D |

## Verification
A single edge can combine a change of the shared loop control with a shift. That same edge can also clock one lane of a pair while the other lane stays idle. The bench provokes this by flipping `loop_ab` or `loop_cd` before each edge, and by clocking only some lanes in a step. A scoreboard model is updated only for the lanes that actually receive an edge. It predicts every output, so a lane that shifted with the wrong source, or changed while idle, is reported against the requirement of the phase under test.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
    typedef enum logic {
        SRC_EXT  = 1'b0,
        SRC_LOOP = 1'b1
    } src_sel_e;

    localparam int unsigned LANES = 4;
endpackage

// File: rtl/qsr_src_mux.sv
module qsr_src_mux
    import qsr_pkg::*;
(
    input  logic loop_en,
    input  logic ext_bit,
    input  logic fb_bit,
    output logic head_bit
);
    src_sel_e sel;

    always_comb begin
        sel = loop_en ? SRC_LOOP : SRC_EXT;
    end

    always_comb begin
        unique case (sel)
            SRC_EXT:  head_bit = ext_bit;
            SRC_LOOP: head_bit = fb_bit;
            default:  head_bit = ext_bit;
        endcase
    end
endmodule

// File: rtl/qsr_lane.sv
module qsr_lane #(
    parameter int unsigned STAGES = 64
) (
    input  logic clk,
    input  logic loop_en,
    input  logic sin,
    output logic sout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stage;
    logic          head;

    qsr_src_mux u_mux (
        .loop_en  (loop_en),
        .ext_bit  (sin),
        .fb_bit   (stage[LAST]),
        .head_bit (head)
    );

    always_ff @(posedge clk) begin
        stage <= {stage[LAST-1:0], head};
    end

    always_comb begin
        sout = stage[LAST];
    end

    // assertion support: becomes 1 after the first edge of this lane
    logic seen_edge = 1'b0;
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    a_r4_loop_feeds_head: assert property (@(posedge clk) disable iff (!seen_edge)
        loop_en |=> (stage[0] == $past(sout)));

    a_r5_ext_feeds_head: assert property (@(posedge clk) disable iff (!seen_edge)
        !loop_en |=> (stage[0] == $past(sin)));

    a_r2_tail_advance: assert property (@(posedge clk) disable iff (!seen_edge)
        1'b1 |=> (sout == $past(stage[LAST-1])));

    a_r2_head_advance: assert property (@(posedge clk) disable iff (!seen_edge)
        1'b1 |=> (stage[1] == $past(stage[0])));
endmodule

// File: rtl/quad_recirc_shreg.sv
module quad_recirc_shreg
    import qsr_pkg::*;
#(
    parameter int unsigned STAGES = 64
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic clk_c,
    input  logic clk_d,
    input  logic sin_a,
    input  logic sin_b,
    input  logic sin_c,
    input  logic sin_d,
    input  logic loop_ab,
    input  logic loop_cd,
    output logic sout_a,
    output logic sout_b,
    output logic sout_c,
    output logic sout_d
);
    logic [LANES-1:0] clk_v;
    logic [LANES-1:0] sin_v;
    logic [LANES-1:0] loop_v;
    logic [LANES-1:0] sout_v;

    assign clk_v = {clk_d, clk_c, clk_b, clk_a};
    assign sin_v = {sin_d, sin_c, sin_b, sin_a};

    // lanes 0,1 share loop_ab; lanes 2,3 share loop_cd
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign loop_v[g] = (g < 2) ? loop_ab : loop_cd;

            qsr_lane #(.STAGES(STAGES)) u_lane (
                .clk     (clk_v[g]),
                .loop_en (loop_v[g]),
                .sin     (sin_v[g]),
                .sout    (sout_v[g])
            );
        end
    endgenerate

    assign sout_a = sout_v[0];
    assign sout_b = sout_v[1];
    assign sout_c = sout_v[2];
    assign sout_d = sout_v[3];
endmodule

// File: tb/quad_recirc_shreg_tb.sv
module quad_recirc_shreg_tb;
    localparam int unsigned STAGES = 64;

    logic tick = 1'b0;
    always #5 tick = ~tick;

    logic clk_a = 0, clk_b = 0, clk_c = 0, clk_d = 0;
    logic [3:0] sin_drv = '0;
    logic loop_ab = 0, loop_cd = 0;
    logic casc = 0;
    logic sin_b_eff;
    logic sout_a, sout_b, sout_c, sout_d;

    assign sin_b_eff = casc ? sout_a : sin_drv[1];

    quad_recirc_shreg #(.STAGES(STAGES)) u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c), .clk_d(clk_d),
        .sin_a(sin_drv[0]), .sin_b(sin_b_eff), .sin_c(sin_drv[2]), .sin_d(sin_drv[3]),
        .loop_ab(loop_ab), .loop_cd(loop_cd),
        .sout_a(sout_a), .sout_b(sout_b), .sout_c(sout_c), .sout_d(sout_d)
    );

    typedef struct {
        int    lane;
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R5";

    logic mdl [4][STAGES];
    bit   kn  [4][STAGES];
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic dut_out(int l);
        case (l)
            0: return sout_a;
            1: return sout_b;
            2: return sout_c;
            default: return sout_d;
        endcase
    endfunction

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic  act;
                it  = q.pop_front();
                act = dut_out(it.lane);
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s lane %0d: actual %b expected %b", it.tag, it.lane, act, it.exp);
                end
            end
        end
    end

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // driver: one shift step on the lanes in mask, then push expectations
    task automatic step(input logic [3:0] mask);
        logic nb [4];
        bit   nk [4];
        @(negedge tick);
        for (int l = 0; l < 4; l++) begin
            logic lp;
            lp = (l < 2) ? loop_ab : loop_cd;
            if (lp) begin
                nb[l] = mdl[l][STAGES-1]; nk[l] = kn[l][STAGES-1];
            end else if (l == 1 && casc) begin
                nb[l] = mdl[0][STAGES-1]; nk[l] = kn[0][STAGES-1];
            end else begin
                nb[l] = sin_drv[l]; nk[l] = 1'b1;
            end
        end
        @(posedge tick);
        clk_a = mask[0]; clk_b = mask[1]; clk_c = mask[2]; clk_d = mask[3];
        #1;
        for (int l = 0; l < 4; l++) begin
            if (mask[l]) begin
                for (int s = STAGES - 1; s > 0; s--) begin
                    mdl[l][s] = mdl[l][s-1]; kn[l][s] = kn[l][s-1];
                end
                mdl[l][0] = nb[l]; kn[l][0] = nk[l];
            end
        end
        for (int l = 0; l < 4; l++) begin
            if (kn[l][STAGES-1]) begin
                item_t it;
                it.lane = l; it.exp = mdl[l][STAGES-1]; it.tag = cur_tag;
                q.push_back(it);
            end
        end
        ->chk_ev;
        @(negedge tick);
        clk_a = 0; clk_b = 0; clk_c = 0; clk_d = 0;
    endtask

    task automatic direct(input string tag, input int l, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s lane %0d: actual %b expected %b", tag, l, act, exp);
        end
    endtask

    int wd = 0;
    always @(posedge tick) begin
        wd++;
        if (wd > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic snap [STAGES];
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < STAGES; s++) begin mdl[l][s] = 1'b0; kn[l][s] = 1'b0; end

        // R5: fill every lane from its serial input
        cur_tag = "R5";
        for (int i = 0; i < STAGES + 8; i++) begin
            sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
            step(4'hF);
        end

        // R1: lone 1 in zeros reaches the output after exactly STAGES edges
        cur_tag = "R1";
        for (int i = 0; i < 2 * STAGES + 4; i++) begin
            sin_drv = (i == 3) ? 4'hF : 4'h0;
            step(4'hF);
            if (i == 3 + STAGES - 2) direct("R1", 0, sout_a, 1'b0);
            if (i == 3 + STAGES - 1) direct("R1", 0, sout_a, 1'b1);
        end

        // R2: clock one lane at a time, others must hold
        cur_tag = "R2";
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < 20; i++) begin
                sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
                step(4'(1 << l));
            end

        // R4/R6: circulate lane A with random input; output period STAGES
        cur_tag = "R4";
        loop_ab = 1;
        for (int i = 0; i < STAGES; i++) begin
            sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
            step(4'h3);
            snap[i] = sout_a;
        end
        cur_tag = "R6";
        for (int i = 0; i < STAGES; i++) begin
            sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
            step(4'h3);
            if (i % 8 == 5) direct("R6", 0, sout_a, snap[i]);
        end

        // R3: loop_ab high, loop_cd low, all lanes clocked
        cur_tag = "R3";
        for (int i = 0; i < STAGES + 10; i++) begin
            sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
            step(4'hF);
        end

        // R8: loop controls change before every edge
        cur_tag = "R8";
        for (int i = 0; i < 3 * STAGES; i++) begin
            loop_ab = next_bit();
            loop_cd = next_bit();
            sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
            step(4'hF);
        end

        // R9: toggle shared controls with C and D idle, only A clocked
        cur_tag = "R9";
        for (int i = 0; i < 40; i++) begin
            @(negedge tick);
            loop_cd = ~loop_cd;
            loop_ab = next_bit();
            sin_drv = {next_bit(), next_bit(), next_bit(), next_bit()};
            step(4'h1);
        end

        // R7: lane A output drives lane B input, both clocked together
        cur_tag = "R7";
        loop_ab = 0; casc = 1;
        for (int i = 0; i < 3 * STAGES; i++) begin
            sin_drv = (i == 2) ? 4'h1 : 4'h0;
            step(4'h3);
            if (i == 2 + 2 * STAGES - 1) direct("R7", 1, sout_b, 1'b1);
            if (i == 2 + 2 * STAGES - 2) direct("R7", 1, sout_b, 1'b0);
        end
        casc = 0;

        #20;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule